// File: doc/BRIEF.md
# ADC Event and Interrupt Hub

This block gathers single-cycle event pulses from an ADC datapath into sticky status bits and turns them into a CPU interrupt line and per-slot DMA trigger pulses. Two event groups exist side by side. The CPU group records one result-ready event per result slot plus eight conversion events. The DMA group records only the result-ready events. Each group has its own raw status, mask and masked view, and software clears each group on its own.

Software reaches the block through a simple bus port with valid, write, address and data. Mask bits are changed through separate set and clear addresses, so no read-modify-write is needed. Status bits are cleared by writing ones. A DMA-enable bit gates the trigger pulses. The hardware drops it when the DMA-done event arrives, and software must set it again before further triggers are issued.

Top module: `adc_evt_hub`

## Requirements
- R1: After a synchronous reset, every status and mask bit, the DMA enable, the interrupt, the triggers and the read data are zero.
- R2: An event pulse sets its CPU raw bit at the same clock edge, and the bit stays set until software clears it. Bit layout: bits [NSLOT-1:0] are the slot result events. Bits NSLOT+0..7 are ad-hoc done, underflow, DMA done, window-in, window-low, window-high, timeout and overflow.
- R3: A read of the masked address returns the group's raw status ANDed with its mask. The CPU masked view is at address 1 and the DMA masked view is at address 6.
- R4: A write to a mask-set address (2 for CPU, 7 for DMA) sets the mask bits that are written as one. A write to a mask-clear address (3 for CPU, 8 for DMA) clears the mask bits that are written as one. Zero bits leave the mask unchanged. A read of either address returns the mask.
- R5: A write to a status-clear address (4 for CPU, 9 for DMA) clears the raw bits written as one and leaves the other bits unchanged.
- R6: If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: cpu_irq_o is the OR of the CPU masked status. It updates at the same edge as the status and mask.
- R8: The DMA raw status, at address 5, records only slot events. Its mask and clear are independent of the CPU group.
- R9: A slot event drives dma_trig_o for that slot high for one cycle, at the clock edge after the event, only if the DMA mask bit and the DMA enable were both set when the event arrived.
- R10: The DMA-done event clears the DMA enable at the next edge. This wins over a software write of one in the same cycle. The enable is written by bit 0 at address 10 and read back there.
- R11: Read data and bus_rvalid_o appear one cycle after a read request. Reads of the clear addresses and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_done_i | input | NSLOT | Per-slot result-ready pulses |
| misc_evt_i | input | 8 | Conversion event pulses, in the order listed in R2 |
| bus_valid_i | input | 1 | Bus request strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid |
| cpu_irq_o | output | 1 | CPU interrupt request |
| dma_trig_o | output | NSLOT | Per-slot DMA trigger pulses |
| dma_en_o | output | 1 | Current DMA enable |

## Verification
A corrupted raw or mask bit in the CPU group shows on cpu_irq_o at the very next edge. A corrupted DMA mask or enable appears as a missing or extra dma_trig_o pulse on the first slot event after the corruption. Hidden state that has not yet reached an output is exposed by reading raw, masked and mask addresses. The read result arrives one cycle after the request. A reference model compares the interrupt, triggers, enable and every returned read word on each clock. Because of this, a divergence is reported within one cycle of when it becomes observable.

// File: rtl/adc_evt_pkg.sv
package adc_evt_pkg;
  localparam int MISC_N = 8;
  localparam int REG_AW = 4;

  // misc event positions (offset by NSLOT inside the CPU vector)
  localparam int EV_ADHOC   = 0;
  localparam int EV_UNDER   = 1;
  localparam int EV_DMADONE = 2;
  localparam int EV_WIN_IN  = 3;
  localparam int EV_WIN_LO  = 4;
  localparam int EV_WIN_HI  = 5;
  localparam int EV_TMO     = 6;
  localparam int EV_OVF     = 7;

  typedef enum logic [REG_AW-1:0] {
    A_CRAW  = 4'd0,
    A_CMSKD = 4'd1,
    A_CMSET = 4'd2,
    A_CMCLR = 4'd3,
    A_CCLR  = 4'd4,
    A_DRAW  = 4'd5,
    A_DMSKD = 4'd6,
    A_DMSET = 4'd7,
    A_DMCLR = 4'd8,
    A_DCLR  = 4'd9,
    A_CTRL  = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/adc_evt_group.sv
module adc_evt_group #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mset_i,
  input  logic [W-1:0] mclr_i,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] mask_q,
  output logic         any_q
);
  logic [W-1:0] raw_nxt;
  logic [W-1:0] mask_nxt;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // an arriving event overrides a same-cycle clear
    assign raw_nxt[b]  = evt_i[b] | (raw_q[b] & ~clr_i[b]);
    assign mask_nxt[b] = mset_i[b] | (mask_q[b] & ~mclr_i[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      any_q  <= 1'b0;
    end else begin
      raw_q  <= raw_nxt;
      mask_q <= mask_nxt;
      any_q  <= |(raw_nxt & mask_nxt);
    end
  end
endmodule

// File: rtl/adc_evt_regif.sv
module adc_evt_regif
  import adc_evt_pkg::*;
#(
  parameter int DW = 32,
  parameter int EW = 16,
  parameter int NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic [EW-1:0]     cpu_raw_i,
  input  logic [EW-1:0]     cpu_mask_i,
  input  logic [NS-1:0]     dma_raw_i,
  input  logic [NS-1:0]     dma_mask_i,
  input  logic              dma_en_i,
  output logic [EW-1:0]     cpu_clr_o,
  output logic [EW-1:0]     cpu_mset_o,
  output logic [EW-1:0]     cpu_mclr_o,
  output logic [NS-1:0]     dma_clr_o,
  output logic [NS-1:0]     dma_mset_o,
  output logic [NS-1:0]     dma_mclr_o,
  output logic              ctrl_wr_o,
  output logic              ctrl_val_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  logic          wr, rd;
  logic [DW-1:0] rd_nxt;
  logic          unused_wdata_hi;

  assign wr = bus_valid_i & bus_write_i;
  assign rd = bus_valid_i & ~bus_write_i;
  assign unused_wdata_hi = ^bus_wdata_i[DW-1:EW];

  assign cpu_clr_o  = (wr && bus_addr_i == A_CCLR)  ? bus_wdata_i[EW-1:0] : '0;
  assign cpu_mset_o = (wr && bus_addr_i == A_CMSET) ? bus_wdata_i[EW-1:0] : '0;
  assign cpu_mclr_o = (wr && bus_addr_i == A_CMCLR) ? bus_wdata_i[EW-1:0] : '0;
  assign dma_clr_o  = (wr && bus_addr_i == A_DCLR)  ? bus_wdata_i[NS-1:0] : '0;
  assign dma_mset_o = (wr && bus_addr_i == A_DMSET) ? bus_wdata_i[NS-1:0] : '0;
  assign dma_mclr_o = (wr && bus_addr_i == A_DMCLR) ? bus_wdata_i[NS-1:0] : '0;
  assign ctrl_wr_o  = wr && bus_addr_i == A_CTRL;
  assign ctrl_val_o = bus_wdata_i[0];

  always_comb begin
    rd_nxt = '0;
    case (bus_addr_i)
      A_CRAW:          rd_nxt = DW'(cpu_raw_i);
      A_CMSKD:         rd_nxt = DW'(cpu_raw_i & cpu_mask_i);
      A_CMSET, A_CMCLR: rd_nxt = DW'(cpu_mask_i);
      A_DRAW:          rd_nxt = DW'(dma_raw_i);
      A_DMSKD:         rd_nxt = DW'(dma_raw_i & dma_mask_i);
      A_DMSET, A_DMCLR: rd_nxt = DW'(dma_mask_i);
      A_CTRL:          rd_nxt = DW'(dma_en_i);
      default:         rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_nxt;
    end
  end
endmodule

// File: rtl/adc_evt_dma_ctl.sv
module adc_evt_dma_ctl #(
  parameter int NS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] slot_evt_i,
  input  logic [NS-1:0] dma_mask_i,
  input  logic          done_i,
  input  logic          ctrl_wr_i,
  input  logic          ctrl_val_i,
  output logic          en_q,
  output logic [NS-1:0] trig_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      trig_q <= '0;
    end else begin
      trig_q <= en_q ? (slot_evt_i & dma_mask_i) : '0;
      // completion from hardware takes precedence over a software set
      if (done_i)         en_q <= 1'b0;
      else if (ctrl_wr_i) en_q <= ctrl_val_i;
    end
  end
endmodule

// File: rtl/adc_evt_hub.sv
module adc_evt_hub
  import adc_evt_pkg::*;
#(
  parameter int NSLOT  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLOT-1:0]  slot_done_i,
  input  logic [MISC_N-1:0] misc_evt_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              cpu_irq_o,
  output logic [NSLOT-1:0]  dma_trig_o,
  output logic              dma_en_o
);
  localparam int EVT_W = NSLOT + MISC_N;

  logic [EVT_W-1:0] cpu_evt, cpu_clr, cpu_mset, cpu_mclr, cpu_raw_q, cpu_mask_q;
  logic [NSLOT-1:0] dma_clr, dma_mset, dma_mclr, dma_raw_q, dma_mask_q;
  logic             ctrl_wr, ctrl_val, unused_dma_any;

  assign cpu_evt = {misc_evt_i, slot_done_i};

  adc_evt_group #(.W(EVT_W)) u_cpu (
    .clk(clk), .rst(rst), .evt_i(cpu_evt), .clr_i(cpu_clr),
    .mset_i(cpu_mset), .mclr_i(cpu_mclr),
    .raw_q(cpu_raw_q), .mask_q(cpu_mask_q), .any_q(cpu_irq_o)
  );

  adc_evt_group #(.W(NSLOT)) u_dma (
    .clk(clk), .rst(rst), .evt_i(slot_done_i), .clr_i(dma_clr),
    .mset_i(dma_mset), .mclr_i(dma_mclr),
    .raw_q(dma_raw_q), .mask_q(dma_mask_q), .any_q(unused_dma_any)
  );

  adc_evt_regif #(.DW(DATA_W), .EW(EVT_W), .NS(NSLOT)) u_regif (
    .clk(clk), .rst(rst),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .cpu_raw_i(cpu_raw_q), .cpu_mask_i(cpu_mask_q),
    .dma_raw_i(dma_raw_q), .dma_mask_i(dma_mask_q), .dma_en_i(dma_en_o),
    .cpu_clr_o(cpu_clr), .cpu_mset_o(cpu_mset), .cpu_mclr_o(cpu_mclr),
    .dma_clr_o(dma_clr), .dma_mset_o(dma_mset), .dma_mclr_o(dma_mclr),
    .ctrl_wr_o(ctrl_wr), .ctrl_val_o(ctrl_val),
    .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o)
  );

  adc_evt_dma_ctl #(.NS(NSLOT)) u_dma_ctl (
    .clk(clk), .rst(rst), .slot_evt_i(slot_done_i), .dma_mask_i(dma_mask_q),
    .done_i(misc_evt_i[EV_DMADONE]), .ctrl_wr_i(ctrl_wr), .ctrl_val_i(ctrl_val),
    .en_q(dma_en_o), .trig_q(dma_trig_o)
  );
endmodule

// File: rtl/adc_evt_hub_chk.sv
module adc_evt_hub_chk
  import adc_evt_pkg::*;
#(
  parameter int NS = 8,
  parameter int EW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NS-1:0]     slot_done_i,
  input logic [MISC_N-1:0] misc_evt_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic              bus_rvalid_o,
  input logic              cpu_irq_o,
  input logic [NS-1:0]     dma_trig_o,
  input logic              dma_en_o,
  input logic [EW-1:0]     cpu_raw,
  input logic [EW-1:0]     cpu_mask
);
  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq_o == |(cpu_raw & cpu_mask));

  // R2
  evt_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((cpu_raw & $past({misc_evt_i, slot_done_i})) == $past({misc_evt_i, slot_done_i})));

  // R9
  trig_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && (|dma_trig_o) |-> $past(dma_en_o));

  // R9
  trig_needs_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((dma_trig_o & ~$past(slot_done_i)) == '0));

  // R10
  done_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(misc_evt_i[EV_DMADONE]) |-> !dma_en_o);

  // R11
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (bus_rvalid_o == $past(bus_valid_i && !bus_write_i)));
endmodule

bind adc_evt_hub adc_evt_hub_chk #(.NS(NSLOT), .EW(EVT_W)) u_chk (
  .clk(clk), .rst(rst), .slot_done_i(slot_done_i), .misc_evt_i(misc_evt_i),
  .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
  .bus_rvalid_o(bus_rvalid_o), .cpu_irq_o(cpu_irq_o),
  .dma_trig_o(dma_trig_o), .dma_en_o(dma_en_o),
  .cpu_raw(cpu_raw_q), .cpu_mask(cpu_mask_q)
);

// File: tb/adc_evt_hub_test.sv
`timescale 1ns/1ps
module adc_evt_hub_test;
  localparam int NS = 8;
  localparam int EW = NS + 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] slot = '0;
  logic [7:0]    misc = '0;
  logic          bv = 1'b0, bw = 1'b0;
  logic [3:0]    ba = '0;
  logic [DW-1:0] bd = '0;
  logic [DW-1:0] rdata;
  logic          rvalid, irq, en;
  logic [NS-1:0] trig;

  always #2.5 clk = ~clk;

  adc_evt_hub #(.NSLOT(NS), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .slot_done_i(slot), .misc_evt_i(misc),
    .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bd),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .cpu_irq_o(irq),
    .dma_trig_o(trig), .dma_en_o(en)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit [EW-1:0] m_craw, m_cmask;
  bit [NS-1:0] m_draw, m_dmask, m_trig;
  bit          m_en, m_irq, m_rv;
  bit [31:0]   m_rd;

  function automatic bit [31:0] m_read(input int a);
    case (a)
      0: return 32'(m_craw);
      1: return 32'(m_craw & m_cmask);
      2, 3: return 32'(m_cmask);
      5: return 32'(m_draw);
      6: return 32'(m_draw & m_dmask);
      7, 8: return 32'(m_dmask);
      10: return {31'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_craw = '0; m_cmask = '0; m_draw = '0; m_dmask = '0;
      m_trig = '0; m_en = 0; m_irq = 0; m_rv = 0; m_rd = '0;
    end else begin
      bit [EW-1:0] ev;
      bit wr;
      int a;
      ev = {misc, slot};
      wr = bv && bw;
      a = int'(ba);
      m_trig = m_en ? (slot & m_dmask) : '0;
      m_rv = bv && !bw;
      if (m_rv) m_rd = m_read(a);
      if (wr && a == 2) m_cmask = m_cmask | bd[EW-1:0];
      if (wr && a == 3) m_cmask = m_cmask & ~bd[EW-1:0];
      if (wr && a == 4) m_craw = m_craw & ~bd[EW-1:0];
      if (wr && a == 7) m_dmask = m_dmask | bd[NS-1:0];
      if (wr && a == 8) m_dmask = m_dmask & ~bd[NS-1:0];
      if (wr && a == 9) m_draw = m_draw & ~bd[NS-1:0];
      if (wr && a == 10) m_en = bd[0];
      if (misc[2]) m_en = 0;
      m_craw = m_craw | ev;
      m_draw = m_draw | slot;
      m_irq = |(m_craw & m_cmask);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R7 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      chk("R9 trig vs model", 32'(trig), 32'(m_trig));
      chk("R10 enable vs model", {31'd0, en}, {31'd0, m_en});
      chk("R11 rvalid vs model", {31'd0, rvalid}, {31'd0, m_rv});
      if (m_rv) chk("R11 rdata vs model", rdata, m_rd);
    end
  end

  // one bus/event cycle, everything returned to idle afterwards
  task automatic step(input logic [NS-1:0] s, input logic [7:0] m,
                      input logic v, input logic w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    slot = s; misc = m; bv = v; bw = w; ba = a; bd = d;
    @(negedge clk);
    slot = '0; misc = '0; bv = 0; bw = 0; ba = '0; bd = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step('0, '0, 1, 1, a, d);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    step('0, '0, 1, 0, a, 32'd0);
    chk(tag, rdata, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 trig", 32'(trig), 32'd0);
    chk("R1 enable", {31'd0, en}, 32'd0);
    rd(4'd0, 32'd0, "R1 cpu raw");
    rd(4'd2, 32'd0, "R1 cpu mask");
    rd(4'd5, 32'd0, "R1 dma raw");
    rd(4'd10, 32'd0, "R1 ctrl");

    // R2 slot 3 and ad-hoc done (bit NS+0)
    step(8'h08, 8'h01, 0, 0, 4'd0, 32'd0);
    rd(4'd0, 32'h0108, "R2 raw after events");
    chk("R7 irq masked off", {31'd0, irq}, 32'd0);

    wr(4'd2, 32'h0108);
    chk("R7 irq after unmask", {31'd0, irq}, 32'd1);
    rd(4'd1, 32'h0108, "R3 cpu masked");
    wr(4'd3, 32'h0008);
    rd(4'd2, 32'h0100, "R4 mask after clear");
    rd(4'd1, 32'h0100, "R3 masked after mask clear");
    wr(4'd2, 32'h0000);
    rd(4'd3, 32'h0100, "R4 zero set no effect");

    wr(4'd4, 32'h0000);
    rd(4'd0, 32'h0108, "R5 zero clear no effect");
    wr(4'd4, 32'h0100);
    chk("R7 irq after clear", {31'd0, irq}, 32'd0);
    rd(4'd0, 32'h0008, "R5 raw after clear");

    // R6 event on slot 5 together with a clear of bit 5
    step(8'h20, 8'h00, 1, 1, 4'd4, 32'h20);
    rd(4'd0, 32'h0028, "R6 event beats clear");

    rd(4'd5, 32'h28, "R8 dma raw slots only");
    wr(4'd9, 32'h08);
    rd(4'd5, 32'h20, "R8 dma clear");
    rd(4'd0, 32'h0028, "R8 cpu raw untouched by dma clear");
    wr(4'd7, 32'h20);
    rd(4'd6, 32'h20, "R3 dma masked");
    rd(4'd2, 32'h0100, "R8 cpu mask independent");

    wr(4'd10, 32'h1);
    chk("R10 enable set", {31'd0, en}, 32'd1);
    step(8'h20, 8'h00, 0, 0, 4'd0, 32'd0);
    chk("R9 trigger slot 5", 32'(trig), 32'h20);
    @(negedge clk);
    chk("R9 trigger one cycle", 32'(trig), 32'h0);
    step(8'h04, 8'h00, 0, 0, 4'd0, 32'd0);
    chk("R9 unmasked slot no trigger", 32'(trig), 32'h0);

    step(8'h00, 8'h04, 0, 0, 4'd0, 32'd0);
    chk("R10 done clears enable", {31'd0, en}, 32'd0);
    step(8'h20, 8'h00, 0, 0, 4'd0, 32'd0);
    chk("R10 no trigger when disabled", 32'(trig), 32'h0);
    wr(4'd10, 32'h1);
    step(8'h00, 8'h04, 1, 1, 4'd10, 32'h1);
    chk("R10 done beats set", {31'd0, en}, 32'd0);
    wr(4'd10, 32'h1);
    rd(4'd10, 32'h1, "R10 enable readback");

    rd(4'd4, 32'h0, "R11 clear address reads zero");
    rd(4'd15, 32'h0, "R11 unmapped reads zero");

    // random traffic, model compared every clock
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      slot = NS'($urandom & $urandom & $urandom);
      misc = 8'($urandom & $urandom & $urandom);
      bv = 1'($urandom);
      bw = 1'($urandom);
      ba = 4'($urandom_range(0, 11));
      bd = $urandom;
    end
    @(negedge clk);
    slot = '0; misc = '0; bv = 0; bw = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule